// File: doc/BRIEF.md
# Interleaved Processor/Group Backlog Window Decoder

This block decodes a memory-mapped window. The window's pages alternate between two kinds of target. The page number is the bus address shifted right by `PAGE_SHIFT`. Page parity picks the target:

- **Even pages** reach an internal table of virtual-processor entries. Each entry holds a valid flag and an 8-bit pending-priority byte.
- **Odd pages** are forwarded to an external group backlog counter through a request/acknowledge port.

Both targets use the same entry index, which is the page number halved.

The low address bits within a page carry two fields: a 2-bit operation and a 3-bit priority.

- On a processor entry, the operation sets, clears or only reads the pending bit for that priority. The response is the bit's value before the operation.
- On a group entry, the operation, priority, index and an amount are handed to the counter. The counter's returned value comes back as read data.

Loads must be 2 bytes wide and stores 1 byte wide. Any other size is rejected without side effects. A side port lets the surrounding logic load table entries.

Top module: `backlog_window_decoder`

## Requirements
- R1: After reset, `req_ready_o` is 1 and both `rsp_valid_o` and `grp_req_o` are 0. Every table entry is invalid, so any load to an even page returns 16'hFFFF.
- R2: Address decode works as follows.
  - page = `req_addr_i >> PAGE_SHIFT`, and index = page >> 1.
  - Operation = `req_addr_i[9:8]` and priority = `req_addr_i[2:0]`.
  - An even page targets the processor table and an odd page targets the group port.
- R3: On a valid processor entry, operation 2'b00 sets bit mask `8'h80 >> priority` in the pending byte. Operation 2'b01 clears that bit. Operations 2'b10 and 2'b11 leave the byte unchanged.
- R4: A load to a valid processor entry responds one cycle after acceptance. Read data is 16'h0001 if the addressed bit was set before the operation, and 16'h0000 otherwise.
- R5: Size rules:
  - A load with `req_size_i` other than 2, or a store with `req_size_i` other than 1, is rejected.
  - A rejected request changes no table bit and raises no group request.
  - A rejected load responds one cycle later with 16'hFFFF.
- R6: A request to an invalid entry, or to an index at or above `NUM_VP`, leaves the table unchanged. A load to it returns 16'hFFFF.
- R7: An accepted, size-legal odd-page request raises `grp_req_o` in the next cycle. The port carries the index, operation and priority. The amount is the store data byte for stores and 1 for loads. All fields stay stable until `grp_ack_i`.
- R8: While a group request is outstanding, `req_ready_o` is 0. In the cycle after `grp_ack_i`, `grp_req_o` is 0 and `rsp_valid_o` is 1. Read data is `grp_rdata_i` for a load.
- R9: Every store response carries read data 0, whichever target and whether or not the size was legal.
- R10: A pulse on `tbl_we_i` writes `tbl_valid_i` and `tbl_pend_i` into entry `tbl_idx_i`. The write takes effect for requests accepted from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Bus request valid |
| req_ready_o | output | 1 | Block can accept a request |
| req_write_i | input | 1 | 1 = store, 0 = load |
| req_size_i | input | 4 | Access size in bytes |
| req_addr_i | input | ADDR_W | Byte address within the window |
| req_wdata_i | input | 8 | Store data byte |
| rsp_valid_o | output | 1 | One-cycle response strobe |
| rsp_rdata_o | output | DATA_W | Response read data |
| tbl_we_i | input | 1 | Table entry load strobe |
| tbl_idx_i | input | VP_IDX_W | Entry to load |
| tbl_valid_i | input | 1 | Valid flag to load |
| tbl_pend_i | input | 8 | Pending-priority byte to load |
| grp_req_o | output | 1 | Group counter request |
| grp_ack_i | input | 1 | Group counter acknowledge |
| grp_idx_o | output | GIDX_W | Group index |
| grp_op_o | output | 2 | Group operation |
| grp_prio_o | output | 3 | Group priority |
| grp_amount_o | output | 8 | Increment/decrement amount |
| grp_rdata_i | input | DATA_W | Value returned by the counter |

## Verification
A wrong pending bit stays hidden until a later load to the same entry and priority. The bench therefore follows every set and clear with a read-only access, which exposes the stored bit one cycle after acceptance. A broken parity decode or index shift shows up immediately, in one of two ways: a group request appears where none is expected, or a group request carries the wrong index. Size rejection and invalid-entry handling are checked by a follow-up read, which confirms that the bit the request could have touched is unchanged.

// File: rtl/backlog_win_pkg.sv
package backlog_win_pkg;
  localparam int unsigned OP_LSB   = 8;
  localparam int unsigned PRIO_LSB = 0;
  localparam int unsigned LD_SIZE  = 2;
  localparam int unsigned ST_SIZE  = 1;

  typedef enum logic [1:0] {
    OP_SET  = 2'b00,
    OP_CLR  = 2'b01,
    OP_RD_A = 2'b10,
    OP_RD_B = 2'b11
  } bl_op_e;

  typedef enum logic {
    GP_IDLE = 1'b0,
    GP_WAIT = 1'b1
  } gp_state_e;
endpackage

// File: rtl/backlog_req_decode.sv
module backlog_req_decode
  import backlog_win_pkg::*;
#(
  parameter int unsigned ADDR_W     = 24,
  parameter int unsigned PAGE_SHIFT = 12,
  localparam int unsigned PAGE_W    = ADDR_W - PAGE_SHIFT,
  localparam int unsigned GIDX_W    = PAGE_W - 1
) (
  input  logic              write_i,
  input  logic [3:0]        size_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              is_grp_o,
  output logic              size_ok_o,
  output logic [GIDX_W-1:0] idx_o,
  output bl_op_e            op_o,
  output logic [2:0]        prio_o
);
  logic [PAGE_W-1:0] page;

  assign page      = addr_i[ADDR_W-1:PAGE_SHIFT];
  assign is_grp_o  = page[0];
  assign idx_o     = page[PAGE_W-1:1];
  assign op_o      = bl_op_e'(addr_i[OP_LSB +: 2]);
  assign prio_o    = addr_i[PRIO_LSB +: 3];
  assign size_ok_o = write_i ? (size_i == 4'(ST_SIZE)) : (size_i == 4'(LD_SIZE));
endmodule

// File: rtl/backlog_vp_table.sv
module backlog_vp_table
  import backlog_win_pkg::*;
#(
  parameter int unsigned NUM_VP    = 16,
  parameter int unsigned GIDX_W    = 11,
  localparam int unsigned VP_IDX_W = (NUM_VP > 1) ? $clog2(NUM_VP) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                op_en_i,
  input  logic [GIDX_W-1:0]   op_idx_i,
  input  bl_op_e              op_i,
  input  logic [2:0]          prio_i,
  input  logic                ld_we_i,
  input  logic [VP_IDX_W-1:0] ld_idx_i,
  input  logic                ld_valid_i,
  input  logic [7:0]          ld_pend_i,
  output logic                hit_o,
  output logic                old_bit_o
);
  logic [NUM_VP-1:0] valid_q;
  logic [7:0]        pend_q [NUM_VP];
  logic              in_range;
  logic [VP_IDX_W-1:0] sel;
  logic [7:0]        mask;

  assign in_range  = op_idx_i < GIDX_W'(NUM_VP);
  assign sel       = op_idx_i[VP_IDX_W-1:0];
  assign mask      = 8'h80 >> prio_i;
  assign hit_o     = in_range && valid_q[sel];
  assign old_bit_o = hit_o && |(pend_q[sel] & mask);

  for (genvar e = 0; e < NUM_VP; e++) begin : g_ent
    logic ld_hit, op_hit;
    assign ld_hit = ld_we_i && (ld_idx_i == VP_IDX_W'(e));
    assign op_hit = op_en_i && hit_o && (sel == VP_IDX_W'(e));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[e] <= 1'b0;
        pend_q[e]  <= 8'h00;
      end else if (ld_hit) begin
        // side load wins over a same-cycle bus op
        valid_q[e] <= ld_valid_i;
        pend_q[e]  <= ld_pend_i;
      end else if (op_hit) begin
        unique case (op_i)
          OP_SET:  pend_q[e] <= pend_q[e] | mask;
          OP_CLR:  pend_q[e] <= pend_q[e] & ~mask;
          default: pend_q[e] <= pend_q[e];
        endcase
      end
    end
  end
endmodule

// File: rtl/backlog_grp_port.sv
module backlog_grp_port
  import backlog_win_pkg::*;
#(
  parameter int unsigned GIDX_W = 11,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [GIDX_W-1:0] idx_i,
  input  bl_op_e            op_i,
  input  logic [2:0]        prio_i,
  input  logic [7:0]        amount_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] done_data_o,
  output logic              grp_req_o,
  input  logic              grp_ack_i,
  output logic [GIDX_W-1:0] grp_idx_o,
  output logic [1:0]        grp_op_o,
  output logic [2:0]        grp_prio_o,
  output logic [7:0]        grp_amount_o,
  input  logic [DATA_W-1:0] grp_rdata_i
);
  gp_state_e         state_q;
  logic [GIDX_W-1:0] idx_q;
  bl_op_e            op_q;
  logic [2:0]        prio_q;
  logic [7:0]        amt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= GP_IDLE;
      idx_q   <= '0;
      op_q    <= OP_SET;
      prio_q  <= '0;
      amt_q   <= '0;
    end else begin
      unique case (state_q)
        GP_IDLE: if (start_i) begin
          state_q <= GP_WAIT;
          idx_q   <= idx_i;
          op_q    <= op_i;
          prio_q  <= prio_i;
          amt_q   <= amount_i;
        end
        GP_WAIT: if (grp_ack_i) state_q <= GP_IDLE;
        default: state_q <= GP_IDLE;
      endcase
    end
  end

  assign busy_o       = (state_q == GP_WAIT);
  assign grp_req_o    = busy_o;
  assign done_o       = busy_o && grp_ack_i;
  assign done_data_o  = grp_rdata_i;
  assign grp_idx_o    = idx_q;
  assign grp_op_o     = op_q;
  assign grp_prio_o   = prio_q;
  assign grp_amount_o = amt_q;
endmodule

// File: rtl/backlog_window_decoder.sv
module backlog_window_decoder
  import backlog_win_pkg::*;
#(
  parameter int unsigned ADDR_W     = 24,
  parameter int unsigned PAGE_SHIFT = 12,
  parameter int unsigned NUM_VP     = 16,
  parameter int unsigned DATA_W     = 16,
  localparam int unsigned GIDX_W    = ADDR_W - PAGE_SHIFT - 1,
  localparam int unsigned VP_IDX_W  = (NUM_VP > 1) ? $clog2(NUM_VP) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic                req_write_i,
  input  logic [3:0]          req_size_i,
  input  logic [ADDR_W-1:0]   req_addr_i,
  input  logic [7:0]          req_wdata_i,
  output logic                rsp_valid_o,
  output logic [DATA_W-1:0]   rsp_rdata_o,
  input  logic                tbl_we_i,
  input  logic [VP_IDX_W-1:0] tbl_idx_i,
  input  logic                tbl_valid_i,
  input  logic [7:0]          tbl_pend_i,
  output logic                grp_req_o,
  input  logic                grp_ack_i,
  output logic [GIDX_W-1:0]   grp_idx_o,
  output logic [1:0]          grp_op_o,
  output logic [2:0]          grp_prio_o,
  output logic [7:0]          grp_amount_o,
  input  logic [DATA_W-1:0]   grp_rdata_i
);
  localparam logic [DATA_W-1:0] ALL_ONES = '1;

  logic              accept, is_grp, size_ok, grp_go, vp_go;
  logic [GIDX_W-1:0] idx;
  bl_op_e            op;
  logic [2:0]        prio;
  logic              vp_hit, vp_old;
  logic              gp_busy, gp_done;
  logic [DATA_W-1:0] gp_data;
  logic              gp_wr_q;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_data_q, direct_data;

  backlog_req_decode #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT)) u_dec (
    .write_i  (req_write_i),
    .size_i   (req_size_i),
    .addr_i   (req_addr_i),
    .is_grp_o (is_grp),
    .size_ok_o(size_ok),
    .idx_o    (idx),
    .op_o     (op),
    .prio_o   (prio)
  );

  assign req_ready_o = !gp_busy;
  assign accept      = req_valid_i && req_ready_o;
  assign grp_go      = accept && is_grp && size_ok;
  assign vp_go       = accept && !is_grp && size_ok;

  backlog_vp_table #(.NUM_VP(NUM_VP), .GIDX_W(GIDX_W)) u_tbl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .op_en_i   (vp_go),
    .op_idx_i  (idx),
    .op_i      (op),
    .prio_i    (prio),
    .ld_we_i   (tbl_we_i),
    .ld_idx_i  (tbl_idx_i),
    .ld_valid_i(tbl_valid_i),
    .ld_pend_i (tbl_pend_i),
    .hit_o     (vp_hit),
    .old_bit_o (vp_old)
  );

  backlog_grp_port #(.GIDX_W(GIDX_W), .DATA_W(DATA_W)) u_gp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (grp_go),
    .idx_i       (idx),
    .op_i        (op),
    .prio_i      (prio),
    .amount_i    (req_write_i ? req_wdata_i : 8'd1),
    .busy_o      (gp_busy),
    .done_o      (gp_done),
    .done_data_o (gp_data),
    .grp_req_o   (grp_req_o),
    .grp_ack_i   (grp_ack_i),
    .grp_idx_o   (grp_idx_o),
    .grp_op_o    (grp_op_o),
    .grp_prio_o  (grp_prio_o),
    .grp_amount_o(grp_amount_o),
    .grp_rdata_i (grp_rdata_i)
  );

  always_comb begin
    if (req_write_i)                 direct_data = '0;
    else if (!size_ok || !vp_hit)    direct_data = ALL_ONES;
    else                             direct_data = DATA_W'(vp_old);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
      gp_wr_q     <= 1'b0;
    end else begin
      rsp_valid_q <= 1'b0;
      if (grp_go) gp_wr_q <= req_write_i;
      if (gp_done) begin
        rsp_valid_q <= 1'b1;
        rsp_data_q  <= gp_wr_q ? '0 : gp_data;
      end else if (accept && !grp_go) begin
        rsp_valid_q <= 1'b1;
        rsp_data_q  <= direct_data;
      end
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rsp_data_q;
endmodule

// File: rtl/backlog_window_decoder_chk.sv
module backlog_window_decoder_chk #(
  parameter int unsigned ADDR_W     = 24,
  parameter int unsigned PAGE_SHIFT = 12,
  parameter int unsigned NUM_VP     = 16,
  parameter int unsigned DATA_W     = 16,
  localparam int unsigned GIDX_W    = ADDR_W - PAGE_SHIFT - 1,
  localparam int unsigned VP_IDX_W  = (NUM_VP > 1) ? $clog2(NUM_VP) : 1
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_valid_i,
  input logic                req_ready_o,
  input logic                req_write_i,
  input logic [3:0]          req_size_i,
  input logic [ADDR_W-1:0]   req_addr_i,
  input logic [7:0]          req_wdata_i,
  input logic                rsp_valid_o,
  input logic [DATA_W-1:0]   rsp_rdata_o,
  input logic                tbl_we_i,
  input logic [VP_IDX_W-1:0] tbl_idx_i,
  input logic                tbl_valid_i,
  input logic [7:0]          tbl_pend_i,
  input logic                grp_req_o,
  input logic                grp_ack_i,
  input logic [GIDX_W-1:0]   grp_idx_o,
  input logic [1:0]          grp_op_o,
  input logic [2:0]          grp_prio_o,
  input logic [7:0]          grp_amount_o,
  input logic [DATA_W-1:0]   grp_rdata_i
);
  logic acc, legal, odd;
  assign acc   = req_valid_i && req_ready_o;
  assign odd   = req_addr_i[PAGE_SHIFT];
  assign legal = req_write_i ? (req_size_i == 4'd1) : (req_size_i == 4'd2);

  assert_grp_launch_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && odd && legal |=> grp_req_o);

  assert_grp_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grp_req_o && !grp_ack_i |=> grp_req_o && $stable(grp_idx_o) && $stable(grp_op_o)
      && $stable(grp_prio_o) && $stable(grp_amount_o));

  assert_busy_stall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grp_req_o |-> !req_ready_o);

  assert_ack_resp_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grp_req_o && grp_ack_i |=> rsp_valid_o && !grp_req_o);

  assert_direct_resp_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && !(odd && legal) |=> rsp_valid_o && !grp_req_o);

  assert_reject_ones_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && !req_write_i && !legal |=> rsp_rdata_o == '1);

  assert_store_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && req_write_i && !(odd && legal) |=> rsp_rdata_o == '0);
endmodule

bind backlog_window_decoder backlog_window_decoder_chk #(
  .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .NUM_VP(NUM_VP), .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/backlog_window_decoder_tb.sv
`timescale 1ns/100ps
module backlog_window_decoder_tb;
  localparam int unsigned ADDR_W = 24;
  localparam int unsigned DATA_W = 16;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        req_valid_i = 0, req_write_i = 0;
  logic [3:0]  req_size_i = 0;
  logic [23:0] req_addr_i = 0;
  logic [7:0]  req_wdata_i = 0;
  logic        req_ready_o, rsp_valid_o;
  logic [15:0] rsp_rdata_o;
  logic        tbl_we_i = 0, tbl_valid_i = 0;
  logic [3:0]  tbl_idx_i = 0;
  logic [7:0]  tbl_pend_i = 0;
  logic        grp_req_o, grp_ack_i = 0;
  logic [10:0] grp_idx_o;
  logic [1:0]  grp_op_o;
  logic [2:0]  grp_prio_o;
  logic [7:0]  grp_amount_o;
  logic [15:0] grp_rdata_i = 0;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  backlog_window_decoder u_dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // {req tag, write, size, addr, wdata, expected rdata}
  typedef logic [56:0] vec_t;
  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    {4'd4, 1'b0, 4'd2, 24'h000200, 8'h00, 16'h0000}, // R4 idx0 prio0 clear
    {4'd3, 1'b0, 4'd2, 24'h000003, 8'h00, 16'h0000}, // R3 set prio3, old 0
    {4'd3, 1'b0, 4'd2, 24'h000303, 8'h00, 16'h0001}, // R3 read-only op 11
    {4'd3, 1'b0, 4'd2, 24'h000103, 8'h00, 16'h0001}, // R3 clear, old 1
    {4'd3, 1'b0, 4'd2, 24'h000203, 8'h00, 16'h0000}, // R3 cleared
    {4'd10,1'b0, 4'd2, 24'h002200, 8'h00, 16'h0001}, // R10 A5 prio0
    {4'd10,1'b0, 4'd2, 24'h002201, 8'h00, 16'h0000}, // R10 A5 prio1
    {4'd10,1'b0, 4'd2, 24'h002207, 8'h00, 16'h0001}, // R10 A5 prio7
    {4'd9, 1'b1, 4'd1, 24'h002001, 8'h5A, 16'h0000}, // R9 store set prio1
    {4'd3, 1'b0, 4'd2, 24'h002201, 8'h00, 16'h0001}, // R3
    {4'd9, 1'b1, 4'd1, 24'h002107, 8'h00, 16'h0000}, // R9 store clear prio7
    {4'd3, 1'b0, 4'd2, 24'h002207, 8'h00, 16'h0000}, // R3
    {4'd6, 1'b0, 4'd2, 24'h004200, 8'h00, 16'hFFFF}, // R6 invalid entry
    {4'd6, 1'b0, 4'd2, 24'h004000, 8'h00, 16'hFFFF}, // R6 invalid set
    {4'd6, 1'b0, 4'd2, 24'h020200, 8'h00, 16'hFFFF}, // R6 idx 16 out of range
    {4'd5, 1'b0, 4'd1, 24'h000005, 8'h00, 16'hFFFF}, // R5 load size 1
    {4'd5, 1'b0, 4'd2, 24'h000205, 8'h00, 16'h0000}, // R5 untouched
    {4'd5, 1'b1, 4'd2, 24'h000006, 8'hFF, 16'h0000}, // R5 store size 2
    {4'd5, 1'b0, 4'd2, 24'h000206, 8'h00, 16'h0000}, // R5 untouched
    {4'd2, 1'b0, 4'd2, 24'h006207, 8'h00, 16'h0001}, // R2 idx3 prio7
    {4'd2, 1'b0, 4'd2, 24'h006200, 8'h00, 16'h0000}, // R2 idx3 prio0
    {4'd4, 1'b0, 4'd2, 24'h000003, 8'h00, 16'h0000}  // R4 set again, old 0
  };

  task automatic issue(logic wr, logic [3:0] sz, logic [23:0] a, logic [7:0] d);
    @(negedge clk_i);
    req_valid_i = 1; req_write_i = wr; req_size_i = sz; req_addr_i = a; req_wdata_i = d;
    @(negedge clk_i);
    req_valid_i = 0;
  endtask

  task automatic tload(logic [3:0] i, logic v, logic [7:0] p);
    @(negedge clk_i);
    tbl_we_i = 1; tbl_idx_i = i; tbl_valid_i = v; tbl_pend_i = p;
    @(negedge clk_i);
    tbl_we_i = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    chk("R1 ready", 32'(req_ready_o), 1);
    chk("R1 rsp_valid", 32'(rsp_valid_o), 0);
    chk("R1 grp_req", 32'(grp_req_o), 0);
    issue(0, 4'd2, 24'h000200, 0);
    chk("R1 entry invalid after reset", 32'(rsp_rdata_o), 32'hFFFF);

    tload(4'd0, 1, 8'h00);
    tload(4'd1, 1, 8'hA5);
    tload(4'd2, 0, 8'hFF);
    tload(4'd3, 1, 8'h01);

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][52], VEC[i][51:48], VEC[i][47:24], VEC[i][23:16]);
      chk($sformatf("R%0d vec %0d valid", VEC[i][56:53], i), 32'(rsp_valid_o), 1);
      chk($sformatf("R%0d vec %0d data", VEC[i][56:53], i), 32'(rsp_rdata_o), 32'(VEC[i][15:0]));
    end

    // R7/R8: group load, page 3 -> idx 1, op 01, prio 4
    issue(0, 4'd2, 24'h003104, 0);
    chk("R7 grp_req raised", 32'(grp_req_o), 1);
    chk("R7 fields", {grp_idx_o, grp_op_o, grp_prio_o, grp_amount_o}, {11'd1, 2'd1, 3'd4, 8'd1});
    chk("R8 ready low", 32'(req_ready_o), 0);
    chk("R8 no rsp yet", 32'(rsp_valid_o), 0);
    repeat (3) @(negedge clk_i);
    chk("R7 held", {grp_req_o, grp_idx_o, grp_op_o, grp_prio_o, grp_amount_o},
        {1'b1, 11'd1, 2'd1, 3'd4, 8'd1});
    grp_ack_i = 1; grp_rdata_i = 16'h1234;
    @(negedge clk_i);
    grp_ack_i = 0; grp_rdata_i = 0;
    chk("R8 rsp after ack", {rsp_valid_o, grp_req_o, rsp_rdata_o}, {1'b1, 1'b0, 16'h1234});
    @(negedge clk_i);
    chk("R8 single rsp and ready", {rsp_valid_o, req_ready_o}, 2'b01);

    // R7/R9: group store, page 5 -> idx 2, op 00, prio 2, amount 0x37
    issue(1, 4'd1, 24'h005002, 8'h37);
    chk("R7 store fields", {grp_req_o, grp_idx_o, grp_op_o, grp_prio_o, grp_amount_o},
        {1'b1, 11'd2, 2'd0, 3'd2, 8'h37});
    grp_ack_i = 1; grp_rdata_i = 16'hBEEF;
    @(negedge clk_i);
    grp_ack_i = 0;
    chk("R9 group store rsp zero", {rsp_valid_o, rsp_rdata_o}, {1'b1, 16'h0000});

    // R5: rejected odd-page load raises no group request
    issue(0, 4'd4, 24'h003200, 0);
    chk("R5 odd reject", {grp_req_o, rsp_valid_o, rsp_rdata_o}, {1'b0, 1'b1, 16'hFFFF});

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule